// File: doc/BRIEF.md
# SRAM Programming Bus Controller

This block arbitrates ownership of a byte-wide asynchronous SRAM that is shared between a target system and a host-side programming controller. In run mode it lets go of every shared line: the address lanes, the data lanes and the read strobe are all released. The write strobe stays driven inactive, and the target's active-low reset is driven high so the target runs from the memory.

When the host raises its programming-mode request, the controller first holds the target in reset for one cycle without touching the bus. It then takes the address, data and read-strobe lines. From then on it serves single-byte write and read requests with a 17-bit address. Each request ends with a one-cycle done pulse, and a read also returns its byte. Tri-state control is brought out as one output-enable per bus group (address, data, read strobe), so a pad ring or a bench can model the high-impedance state.

The mode machine has three states. `MODE_RUN` moves to `MODE_HOLD` when a programming request arrives. `MODE_HOLD` moves to `MODE_PROG` if the request is still present, or falls back to `MODE_RUN` if it has been withdrawn. `MODE_PROG` returns to `MODE_RUN` once the request has been withdrawn and no transfer is in flight or being accepted. The transfer machine starts in `XF_IDLE`. A write runs through `XF_WSETUP`, `XF_WSTROBE` and `XF_WHOLD`, and a read runs through `XF_RSETUP`, `XF_RWAIT` and `XF_RDONE`. Both return to `XF_IDLE` afterwards. The two timed states, `XF_WSTROBE` and `XF_RWAIT`, leave when a shared down-counter expires.

Top module: `sram_prog_ctrl`

## Requirements
- R1: After reset the controller is in run mode. `tgt_rst_n_o`=1, all three bus output-enables are 0, `mem_we_n_o`=1 and `busy_o`=0.
- R2: A programming-mode request first produces one cycle with `tgt_rst_n_o`=0 and all bus output-enables still 0. In the next cycle the address, data and read-strobe output-enables become 1. `mem_we_n_o` stays 1 throughout this sequence.
- R3: A request made outside programming mode produces `err_o`=1 for exactly one cycle, in the cycle after the request. It does not raise `busy_o` and causes no write strobe and no bus ownership.
- R4: A write drives its address and data for one cycle with `mem_we_n_o`=1. It then holds `mem_we_n_o` low for exactly WE_CYC cycles, keeps address and data unchanged for one more cycle with the strobe high, and raises `done_o` in that cycle. That is 1+WE_CYC cycles after acceptance.
- R5: A read first drives the data lanes to 0x00 with `mem_data_oe_o`=1 for one cycle. It then sets `mem_data_oe_o`=0 and `mem_rd_n_o`=0 for exactly RD_WAIT cycles. In the done cycle, 1+RD_WAIT cycles after acceptance, `mem_rd_n_o`=1 and `mem_data_oe_o`=1 again.
- R6: `busy_o` is 1 from the cycle after acceptance through the done cycle, and 0 in the cycle after done. Requests presented while busy are ignored entirely.
- R7: `rdata_o` in the done cycle of a read equals the byte present on `mem_data_i` at the end of the read window. It holds that value until the next read completes.
- R8: When the programming request is withdrawn during a transfer, the bus stays owned until the transfer is done. The return to run mode, with `tgt_rst_n_o`=1 and all output-enables 0, comes two cycles after the done cycle.
- R9: Request address bits 7:0 appear on `mem_addr_lo_o`, bits 15:8 on `mem_addr_hi_o` and bit 16 on `mem_addr_top_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req_i | input | 1 | Level: 1 requests programming mode |
| req_valid_i | input | 1 | Transfer request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle transfer completion |
| err_o | output | 1 | One-cycle rejection of a request outside programming mode |
| rdata_o | output | 8 | Last byte read |
| mem_addr_lo_o | output | 8 | Address lane, bits 7:0 |
| mem_addr_hi_o | output | 8 | Address lane, bits 15:8 |
| mem_addr_top_o | output | 1 | Address bit 16 |
| mem_addr_oe_o | output | 1 | Drive enable for all address lines |
| mem_data_o | output | 8 | Data driven toward the memory |
| mem_data_oe_o | output | 1 | Drive enable for the data lanes |
| mem_data_i | input | 8 | Data read from the memory |
| mem_we_n_o | output | 1 | Active-low write strobe, always driven |
| mem_rd_n_o | output | 1 | Active-low read strobe value |
| mem_rd_oe_o | output | 1 | Drive enable for the read strobe |
| tgt_rst_n_o | output | 1 | Active-low target reset, always driven |

## Verification
A mode machine stuck in or skipping `MODE_HOLD` shows up as bus ownership appearing in the same cycle as the reset assertion, or never appearing. The checks catch it one cycle after the request. A transfer machine that loses its count shows up as a strobe-low window of the wrong length, or as a done pulse in the wrong cycle, within the first transfer. Stale or overwritten address and data registers show up as wrong bytes read back from the bench memory. That includes the lane that differs only in bit 16. Requests sent while the controller is busy, or outside programming mode, are checked by reading back the untouched location and by counting write strobes.

// File: rtl/sram_prog_pkg.sv
package sram_prog_pkg;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int LANE_W = 8;
    localparam int LANES  = (ADDR_W - 1) / LANE_W;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_PROG = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        XF_IDLE    = 3'd0,
        XF_WSETUP  = 3'd1,
        XF_WSTROBE = 3'd2,
        XF_WHOLD   = 3'd3,
        XF_RSETUP  = 3'd4,
        XF_RWAIT   = 3'd5,
        XF_RDONE   = 3'd6
    } xfer_e;
endpackage

// File: rtl/sram_prog_timer.sv
module sram_prog_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_prog_mode.sv
module sram_prog_mode
    import sram_prog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_req,
    input  logic xfer_idle,
    input  logic accept,
    output logic prog_active,
    output logic own_bus,
    output logic tgt_rst_n
);
    mode_e mode_q, mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN:  if (prog_req) mode_d = MODE_HOLD;
            MODE_HOLD: mode_d = prog_req ? MODE_PROG : MODE_RUN;
            MODE_PROG: if (!prog_req && xfer_idle && !accept) mode_d = MODE_RUN;
            default:   mode_d = MODE_RUN;
        endcase
    end

    always_comb begin
        tgt_rst_n   = (mode_q == MODE_RUN);
        own_bus     = (mode_q == MODE_PROG);
        prog_active = (mode_q == MODE_PROG);
    end

    // R8: ownership is never dropped while a transfer is running
    p_keep_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_bus && !xfer_idle) |=> own_bus);
endmodule

// File: rtl/sram_prog_xfer.sv
module sram_prog_xfer
    import sram_prog_pkg::*;
#(
    parameter int WE_CYC  = 1,
    parameter int RD_WAIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_active,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              accept,
    output logic              idle,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              we_n,
    output logic              rd_n,
    output logic              data_release
);
    localparam int MAX_CYC = (WE_CYC > RD_WAIT) ? WE_CYC : RD_WAIT;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);

    xfer_e st_q, st_d;
    logic tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic err_q;
    logic [DATA_W-1:0] rdata_q;

    assign accept = req_valid && prog_active && (st_q == XF_IDLE);

    sram_prog_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= XF_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= req_valid && !prog_active && (st_q == XF_IDLE);
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_write ? req_wdata : '0;
            end
            if (st_q == XF_RWAIT && tmr_exp) rdata_q <= bus_rdata;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XF_IDLE:    if (accept) st_d = req_write ? XF_WSETUP : XF_RSETUP;
            XF_WSETUP:  st_d = XF_WSTROBE;
            XF_WSTROBE: if (tmr_exp) st_d = XF_WHOLD;
            XF_WHOLD:   st_d = XF_IDLE;
            XF_RSETUP:  st_d = XF_RWAIT;
            XF_RWAIT:   if (tmr_exp) st_d = XF_RDONE;
            XF_RDONE:   st_d = XF_IDLE;
            default:    st_d = XF_IDLE;
        endcase
    end

    always_comb begin
        tmr_load     = (st_q == XF_WSETUP) || (st_q == XF_RSETUP);
        tmr_val      = (st_q == XF_WSETUP) ? WE_LOAD : RD_LOAD;
        idle         = (st_q == XF_IDLE);
        busy         = (st_q != XF_IDLE);
        done         = (st_q == XF_WHOLD) || (st_q == XF_RDONE);
        we_n         = (st_q != XF_WSTROBE);
        rd_n         = (st_q != XF_RWAIT);
        data_release = (st_q == XF_RWAIT);
        err          = err_q;
        rdata        = rdata_q;
    end

    // R6: latched request is frozen for the whole transfer
    p_req_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));
    // R3: a rejection never coincides with a running transfer
    p_err_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R7: read result changes only at the end of a read window
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != XF_RDONE) |-> $stable(rdata_q));
endmodule

// File: rtl/sram_prog_ctrl.sv
module sram_prog_ctrl
    import sram_prog_pkg::*;
#(
    parameter int WE_CYC  = 1,
    parameter int RD_WAIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LANE_W-1:0] mem_addr_lo_o,
    output logic [LANE_W-1:0] mem_addr_hi_o,
    output logic              mem_addr_top_o,
    output logic              mem_addr_oe_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              mem_data_oe_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              mem_we_n_o,
    output logic              mem_rd_n_o,
    output logic              mem_rd_oe_o,
    output logic              tgt_rst_n_o
);
    logic prog_active, own_bus, accept, idle, we_n, rd_n, data_release;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [LANES*LANE_W-1:0] lanes;

    sram_prog_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_req    (prog_req_i),
        .xfer_idle   (idle),
        .accept      (accept),
        .prog_active (prog_active),
        .own_bus     (own_bus),
        .tgt_rst_n   (tgt_rst_n_o)
    );

    sram_prog_xfer #(.WE_CYC(WE_CYC), .RD_WAIT(RD_WAIT)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_active  (prog_active),
        .req_valid    (req_valid_i),
        .req_write    (req_write_i),
        .req_addr     (req_addr_i),
        .req_wdata    (req_wdata_i),
        .bus_rdata    (mem_data_i),
        .accept       (accept),
        .idle         (idle),
        .busy         (busy_o),
        .done         (done_o),
        .err          (err_o),
        .rdata        (rdata_o),
        .addr_q       (addr_q),
        .data_q       (data_q),
        .we_n         (we_n),
        .rd_n         (rd_n),
        .data_release (data_release)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g*LANE_W +: LANE_W] = addr_q[g*LANE_W +: LANE_W];
    end

    always_comb begin
        mem_addr_lo_o  = lanes[0 +: LANE_W];
        mem_addr_hi_o  = lanes[LANE_W +: LANE_W];
        mem_addr_top_o = addr_q[ADDR_W-1];
        mem_addr_oe_o  = own_bus;
        mem_data_o     = data_q;
        mem_data_oe_o  = own_bus && !data_release;
        mem_rd_oe_o    = own_bus;
        mem_we_n_o     = we_n || !own_bus;
        mem_rd_n_o     = rd_n || !own_bus;
    end

    // R1: while the target runs, nothing but the inactive write strobe is driven
    p_run_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst_n_o |-> (!mem_addr_oe_o && !mem_data_oe_o && !mem_rd_oe_o && mem_we_n_o));
    // R2: bus ownership is taken only after the target was already in reset
    p_reset_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_addr_oe_o) |-> $past(!tgt_rst_n_o));
    // R4: address and data are settled before the write strobe falls
    p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> ($stable(addr_q) && $stable(mem_data_o) && mem_data_oe_o));
    // R5: never drive data while the memory is driving it
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n_o |-> !mem_data_oe_o);
    // R6: a done pulse ends the busy period
    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: tb/tb_sram_prog_ctrl.sv
module tb_sram_prog_ctrl;
    localparam int WE_CYC  = 1;
    localparam int RD_WAIT = 5;
    localparam int NV      = 12;
    // {is_write, addr[16:0], wdata, expected read}
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, 17'h00000, 8'hA5, 8'h00},
        {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
        {1'b1, 17'h00A05, 8'h11, 8'h00},
        {1'b1, 17'h10A05, 8'hE2, 8'h00},
        {1'b1, 17'h05A3C, 8'h7D, 8'h00},
        {1'b0, 17'h00000, 8'h00, 8'hA5},
        {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
        {1'b0, 17'h00A05, 8'h00, 8'h11},
        {1'b0, 17'h10A05, 8'h00, 8'hE2},
        {1'b0, 17'h05A3C, 8'h00, 8'h7D},
        {1'b1, 17'h00A05, 8'h4B, 8'h00},
        {1'b0, 17'h00A05, 8'h00, 8'h4B}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic prog_req_i = 1'b0, req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [16:0] req_addr_i = '0;
    logic [7:0] req_wdata_i = '0;
    logic busy_o, done_o, err_o, mem_addr_top_o, mem_addr_oe_o, mem_data_oe_o;
    logic mem_we_n_o, mem_rd_n_o, mem_rd_oe_o, tgt_rst_n_o;
    logic [7:0] rdata_o, mem_addr_lo_o, mem_addr_hi_o, mem_data_o, mem_data_i;
    logic [7:0] mem [1024];
    int total = 0, bad = 0, strobes = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sram_prog_ctrl #(.WE_CYC(WE_CYC), .RD_WAIT(RD_WAIT)) dut (
        .clk(clk), .rst_n(rst_n), .prog_req_i(prog_req_i), .req_valid_i(req_valid_i),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
        .mem_addr_lo_o(mem_addr_lo_o), .mem_addr_hi_o(mem_addr_hi_o),
        .mem_addr_top_o(mem_addr_top_o), .mem_addr_oe_o(mem_addr_oe_o),
        .mem_data_o(mem_data_o), .mem_data_oe_o(mem_data_oe_o), .mem_data_i(mem_data_i),
        .mem_we_n_o(mem_we_n_o), .mem_rd_n_o(mem_rd_n_o), .mem_rd_oe_o(mem_rd_oe_o),
        .tgt_rst_n_o(tgt_rst_n_o)
    );

    function automatic int midx(input logic top, input logic [7:0] hi, input logic [7:0] lo);
        return int'({top, hi[3:0], lo[4:0]});
    endfunction

    // behavioural memory: stores on the rising write strobe, drives on read strobe
    initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    always @(posedge mem_we_n_o)
        if (rst_n && mem_addr_oe_o === 1'b1 && mem_data_oe_o === 1'b1)
            mem[midx(mem_addr_top_o, mem_addr_hi_o, mem_addr_lo_o)] = mem_data_o;
    always @(negedge mem_we_n_o) if (rst_n) strobes++;
    assign mem_data_i = (!mem_rd_n_o && mem_rd_oe_o && !mem_data_oe_o)
                        ? mem[midx(mem_addr_top_o, mem_addr_hi_o, mem_addr_lo_o)] : 8'hEE;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic run_op(input logic w, input logic [16:0] a, input logic [7:0] d, input logic [7:0] e);
        int n = 0, wlow = 0, rlow = 0;
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_wdata_i = d;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(busy_o === 1'b1, "R6 busy after accept", busy_o, 1);
        chk({mem_addr_top_o, mem_addr_hi_o, mem_addr_lo_o} === a, "R9 address lanes",
            {mem_addr_top_o, mem_addr_hi_o, mem_addr_lo_o}, a);
        if (w) chk(mem_data_o === d && mem_we_n_o === 1'b1, "R4 setup cycle", {mem_we_n_o, mem_data_o}, {1'b1, d});
        else   chk(mem_data_o === 8'h00 && mem_data_oe_o === 1'b1, "R5 zero drive", {mem_data_oe_o, mem_data_o}, 9'h100);
        while (done_o !== 1'b1 && n < 50) begin
            if (mem_we_n_o === 1'b0) begin
                wlow++;
                chk(mem_data_o === d && {mem_addr_top_o, mem_addr_hi_o, mem_addr_lo_o} === a,
                    "R4 stable under strobe", mem_data_o, d);
            end
            if (mem_rd_n_o === 1'b0) begin
                rlow++;
                if (mem_data_oe_o !== 1'b0) chk(0, "R5 data released", mem_data_oe_o, 0);
            end
            @(negedge clk);
            n++;
        end
        if (w) begin
            chk(n == 1 + WE_CYC, "R4 done cycle", n, 1 + WE_CYC);
            chk(wlow == WE_CYC && mem_we_n_o === 1'b1, "R4 strobe width", wlow, WE_CYC);
        end else begin
            chk(n == 1 + RD_WAIT, "R5 done cycle", n, 1 + RD_WAIT);
            chk(rlow == RD_WAIT, "R5 read window", rlow, RD_WAIT);
            chk(mem_rd_n_o === 1'b1 && mem_data_oe_o === 1'b1, "R5 bus retaken",
                {mem_rd_n_o, mem_data_oe_o}, 2'b11);
            chk(rdata_o === e, "R7 read data", rdata_o, e);
        end
        @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R6 idle after done", {busy_o, done_o}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tgt_rst_n_o === 1'b1 && mem_addr_oe_o === 1'b0 && mem_data_oe_o === 1'b0 &&
            mem_rd_oe_o === 1'b0 && mem_we_n_o === 1'b1 && busy_o === 1'b0, "R1 reset state",
            {tgt_rst_n_o, mem_addr_oe_o, mem_data_oe_o, mem_rd_oe_o, mem_we_n_o, busy_o}, 6'b100010);

        // R3: request in run mode is rejected
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 17'h00123; req_wdata_i = 8'h77;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(err_o === 1'b1 && busy_o === 1'b0 && mem_addr_oe_o === 1'b0, "R3 error pulse",
            {err_o, busy_o, mem_addr_oe_o}, 3'b100);
        @(negedge clk);
        chk(err_o === 1'b0, "R3 pulse one cycle", err_o, 0);
        chk(strobes == 0, "R3 no strobe", strobes, 0);

        // R2: entry into programming mode
        prog_req_i = 1'b1;
        @(negedge clk);
        chk(tgt_rst_n_o === 1'b0 && mem_addr_oe_o === 1'b0 && mem_data_oe_o === 1'b0 &&
            mem_rd_oe_o === 1'b0 && mem_we_n_o === 1'b1, "R2 hold cycle",
            {tgt_rst_n_o, mem_addr_oe_o, mem_data_oe_o, mem_rd_oe_o, mem_we_n_o}, 5'b00001);
        @(negedge clk);
        chk(tgt_rst_n_o === 1'b0 && mem_addr_oe_o === 1'b1 && mem_data_oe_o === 1'b1 &&
            mem_rd_oe_o === 1'b1 && mem_we_n_o === 1'b1 && mem_rd_n_o === 1'b1, "R2 ownership",
            {tgt_rst_n_o, mem_addr_oe_o, mem_data_oe_o, mem_rd_oe_o, mem_we_n_o, mem_rd_n_o}, 6'b011111);
        chk(strobes == 0, "R2 no spurious strobe", strobes, 0);

        // vector table: writes and read-backs (R4 R5 R7 R9)
        for (int i = 0; i < NV; i++)
            run_op(VEC[i][33], VEC[i][32:16], VEC[i][15:8], VEC[i][7:0]);
        chk(strobes == 6, "R4 strobe count", strobes, 6);

        // R6: request presented while busy is ignored
        run_op(1'b1, 17'h00011, 8'h5E, 8'h00);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 17'h00200; req_wdata_i = 8'h01;
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 17'h00011; req_wdata_i = 8'h99;
        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(strobes == 8, "R6 busy request ignored", strobes, 8);
        run_op(1'b0, 17'h00011, 8'h00, 8'h5E);

        // R8: leave programming mode while a read is running
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 17'h1FFFF;
        @(negedge clk);
        req_valid_i = 1'b0; prog_req_i = 1'b0;
        for (int k = 0; k < 50 && done_o !== 1'b1; k++) begin
            if (mem_addr_oe_o !== 1'b1) chk(0, "R8 owned during transfer", mem_addr_oe_o, 1);
            @(negedge clk);
        end
        chk(rdata_o === 8'h3C, "R7 read before release", rdata_o, 8'h3C);
        @(negedge clk);
        chk(mem_addr_oe_o === 1'b1 && busy_o === 1'b0, "R8 still owned after done",
            {mem_addr_oe_o, busy_o}, 2'b10);
        @(negedge clk);
        chk(tgt_rst_n_o === 1'b1 && mem_addr_oe_o === 1'b0 && mem_data_oe_o === 1'b0 &&
            mem_rd_oe_o === 1'b0 && mem_we_n_o === 1'b1, "R8 released",
            {tgt_rst_n_o, mem_addr_oe_o, mem_data_oe_o, mem_rd_oe_o, mem_we_n_o}, 5'b10001);
        chk(rdata_o === 8'h3C, "R7 read data held", rdata_o, 8'h3C);

        // R3 again after leaving: a read is rejected
        req_valid_i = 1'b1; req_write_i = 1'b0;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(err_o === 1'b1 && busy_o === 1'b0, "R3 reject after release", {err_o, busy_o}, 2'b10);
        report();
    end
endmodule